// File: doc/BRIEF.md
# Counted-Loop Branch Step Unit

This block executes one custom loop-control instruction for a 32-bit load/store processor. In a single operation it tests a counter register, decrements it, and takes a PC-relative branch. The unit holds the program counter. Each cycle it receives the instruction word at that PC and the value already read from the register that the instruction's source field names. From these it produces the following PC and a register write-back request.

If the opcode matches the configured loop opcode and the counter, read as a signed number, is above zero, the unit asks for the counter to be written back one lower. It then steers the PC to a target measured from the sequential successor. In every other case the unit falls through to the next word and requests no write. Any other opcode advances the PC by four and requests no write. Fetch, the register file and pipeline concerns stay outside the block.

Top module: `loop_step_unit`

## Requirements
- R1: While the synchronous active-high reset is sampled high at a rising edge, `pc_o` becomes `RESET_VEC` (default 32'h0000_0400) after that edge.
- R2: When the opcode field (instruction bits [31:26]) differs from `LOOP_OPC` (default 6'h3B), `wb_en_o` is 0 and `next_pc_o` equals `pc_o + 4`.
- R3: For the loop opcode with a nonzero rs field (bits [25:21]) and `rs_val_i` greater than zero as a signed number, `wb_en_o` is 1, `wb_idx_o` equals the rs field and `wb_data_o` equals `rs_val_i - 1`.
- R4: When the branch is taken, `next_pc_o` equals `pc_o + 4 + (sign-extended bits [15:0] shifted left by two)`, so targets both ahead and behind the instruction are reachable.
- R5: For the loop opcode with `rs_val_i` zero or negative (signed), `wb_en_o` is 0 and `next_pc_o` equals `pc_o + 4`.
- R6: For the loop opcode with rs field 0, `wb_en_o` is 0 and `next_pc_o` equals `pc_o + 4`, whatever `rs_val_i` holds.
- R7: Outside reset, `pc_o` takes the value `next_pc_o` had at each rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; PC updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word located at `pc_o` |
| rs_val_i | input | 32 | Register value selected by the rs field |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | PC loaded at the next rising edge |
| wb_en_o | output | 1 | Write-back request for the counter register |
| wb_idx_o | output | 5 | Register index to write |
| wb_data_o | output | 32 | Decremented counter value |

## Verification
`next_pc_o` and the three write-back outputs are combinational in `instr_i`, `rs_val_i` and `pc_o`. They are due in the same cycle the inputs change. `pc_o` is due one rising edge later. The bench drives a new instruction at each falling edge and checks the combinational results 1 ns later. It checks `pc_o` against its own running PC model at the start of the next step, after exactly one rising edge. The sweeps cover every opcode, every rs index, counter values at and around zero and at both signed extremes, and immediates at both signed extremes.

// File: rtl/lpu_pkg.sv
package lpu_pkg;
   localparam int unsigned INSTR_BYTES = 4;

   typedef struct packed {
      logic take;
      logic wr;
   } lpu_ctl_t;
endpackage

// File: rtl/lpu_decode.sv
module lpu_decode #(
   parameter int unsigned OPC_W    = 6,
   parameter int unsigned REG_W    = 5,
   parameter int unsigned IMM_W    = 16,
   parameter logic [OPC_W-1:0] LOOP_OPC = 6'h3B,
   localparam int unsigned INSTR_W = OPC_W + 2*REG_W + IMM_W
) (
   input  logic [INSTR_W-1:0] instr,
   output logic               is_loop,
   output logic [REG_W-1:0]   rs_idx,
   output logic [IMM_W-1:0]   imm
);
   localparam int unsigned OPC_LO = INSTR_W - OPC_W;
   localparam int unsigned RS_LO  = OPC_LO - REG_W;

   assign is_loop = (instr[INSTR_W-1:OPC_LO] == LOOP_OPC);
   assign rs_idx  = instr[OPC_LO-1:RS_LO];
   assign imm     = instr[IMM_W-1:0];
endmodule

// File: rtl/lpu_offset.sv
module lpu_offset #(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned IMM_W = 16
) (
   input  logic [IMM_W-1:0] imm,
   output logic [XLEN-1:0]  off
);
   localparam int unsigned SHIFT = 2;
   localparam int unsigned EXT_W = XLEN - IMM_W - SHIFT;

   generate
      if (XLEN < IMM_W + SHIFT) begin : g_bad_width
         $error("lpu_offset: XLEN too small for shifted immediate");
      end else if (EXT_W == 0) begin : g_no_ext
         assign off = {imm, {SHIFT{1'b0}}};
      end else begin : g_ext
         assign off = {{EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/lpu_count.sv
module lpu_count #(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned REG_W = 5
) (
   input  logic             is_loop,
   input  logic [REG_W-1:0] rs_idx,
   input  logic [XLEN-1:0]  rs_val,
   output lpu_pkg::lpu_ctl_t ctl,
   output logic [XLEN-1:0]  dec_val
);
   logic positive;
   logic idx_live;

   assign positive = !rs_val[XLEN-1] && (rs_val != '0);
   assign idx_live = (rs_idx != '0);
   assign ctl.take = is_loop && idx_live && positive;
   assign ctl.wr   = ctl.take;
   assign dec_val  = rs_val - XLEN'(1);
endmodule

// File: rtl/lpu_pc_reg.sv
module lpu_pc_reg #(
   parameter int unsigned XLEN = 32,
   parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_0400
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [XLEN-1:0] pc_d,
   output logic [XLEN-1:0] pc_q
);
   always_ff @(posedge clk) begin
      if (rst) pc_q <= RESET_VEC;
      else     pc_q <= pc_d;
   end
endmodule

// File: rtl/loop_step_unit.sv
module loop_step_unit #(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned OPC_W = 6,
   parameter int unsigned REG_W = 5,
   parameter int unsigned IMM_W = 16,
   parameter logic [OPC_W-1:0] LOOP_OPC  = 6'h3B,
   parameter logic [XLEN-1:0]  RESET_VEC = 32'h0000_0400
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [31:0]      instr_i,
   input  logic [XLEN-1:0]  rs_val_i,
   output logic [XLEN-1:0]  pc_o,
   output logic [XLEN-1:0]  next_pc_o,
   output logic             wb_en_o,
   output logic [REG_W-1:0] wb_idx_o,
   output logic [XLEN-1:0]  wb_data_o
);
   localparam int unsigned INSTR_W = OPC_W + 2*REG_W + IMM_W;

   generate
      if (INSTR_W != 32) begin : g_bad_instr
         $error("loop_step_unit: field widths must fill a 32-bit word");
      end
      if (RESET_VEC[1:0] != 2'b00) begin : g_bad_vec
         $error("loop_step_unit: reset vector must be word aligned");
      end
   endgenerate

   logic             is_loop;
   logic [REG_W-1:0] rs_idx;
   logic [IMM_W-1:0] imm;
   logic [XLEN-1:0]  off;
   logic [XLEN-1:0]  seq_pc;
   logic [XLEN-1:0]  tgt_pc;
   lpu_pkg::lpu_ctl_t ctl;
   logic [XLEN-1:0]  dec_val;

   lpu_decode #(.OPC_W(OPC_W), .REG_W(REG_W), .IMM_W(IMM_W), .LOOP_OPC(LOOP_OPC)) u_dec (
      .instr(instr_i), .is_loop(is_loop), .rs_idx(rs_idx), .imm(imm));

   lpu_offset #(.XLEN(XLEN), .IMM_W(IMM_W)) u_off (.imm(imm), .off(off));

   lpu_count #(.XLEN(XLEN), .REG_W(REG_W)) u_cnt (
      .is_loop(is_loop), .rs_idx(rs_idx), .rs_val(rs_val_i),
      .ctl(ctl), .dec_val(dec_val));

   assign seq_pc    = pc_o + XLEN'(lpu_pkg::INSTR_BYTES);
   assign tgt_pc    = seq_pc + off;
   assign next_pc_o = ctl.take ? tgt_pc : seq_pc;
   assign wb_en_o   = ctl.wr;
   assign wb_idx_o  = rs_idx;
   assign wb_data_o = dec_val;

   lpu_pc_reg #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_pc (
      .clk(clk), .rst(rst), .pc_d(next_pc_o), .pc_q(pc_o));
endmodule

// File: rtl/lpu_checker.sv
module lpu_checker #(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned OPC_W = 6,
   parameter int unsigned REG_W = 5,
   parameter logic [OPC_W-1:0] LOOP_OPC  = 6'h3B,
   parameter logic [XLEN-1:0]  RESET_VEC = 32'h0000_0400
) (
   input logic             clk,
   input logic             rst,
   input logic [31:0]      instr_i,
   input logic [XLEN-1:0]  rs_val_i,
   input logic [XLEN-1:0]  pc_o,
   input logic [XLEN-1:0]  next_pc_o,
   input logic             wb_en_o,
   input logic [REG_W-1:0] wb_idx_o,
   input logic [XLEN-1:0]  wb_data_o
);
   logic            opc_hit;
   logic [XLEN-1:0] br_off;
   assign opc_hit = (instr_i[31:26] == LOOP_OPC);
   assign br_off  = XLEN'({{14{instr_i[15]}}, instr_i[15:0], 2'b00});

   a_r1_reset_vec: assert property (@(posedge clk) rst |=> pc_o == RESET_VEC);
   a_r2_other_seq: assert property (@(posedge clk) disable iff (rst)
      !opc_hit |-> (!wb_en_o && next_pc_o == pc_o + 4));
   a_r3_wb_value: assert property (@(posedge clk) disable iff (rst)
      wb_en_o |-> (wb_data_o == rs_val_i - 1 && wb_idx_o == instr_i[25:21]));
   a_r4_target: assert property (@(posedge clk) disable iff (rst)
      wb_en_o |-> next_pc_o == pc_o + 4 + br_off);
   a_r5_nonpos: assert property (@(posedge clk) disable iff (rst)
      (opc_hit && $signed(rs_val_i) <= 0) |-> (!wb_en_o && next_pc_o == pc_o + 4));
   a_r6_zero_idx: assert property (@(posedge clk) disable iff (rst)
      (instr_i[25:21] == 5'd0) |-> (!wb_en_o && next_pc_o == pc_o + 4));
   a_r7_pc_follow: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> pc_o == $past(next_pc_o));
endmodule

bind loop_step_unit lpu_checker #(
   .XLEN(XLEN), .OPC_W(OPC_W), .REG_W(REG_W),
   .LOOP_OPC(LOOP_OPC), .RESET_VEC(RESET_VEC)) u_chk (
   .clk(clk), .rst(rst), .instr_i(instr_i), .rs_val_i(rs_val_i),
   .pc_o(pc_o), .next_pc_o(next_pc_o), .wb_en_o(wb_en_o),
   .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o));

// File: tb/sim_loop_step_unit.sv
`timescale 1ns/1ps
module sim_loop_step_unit;
   localparam logic [5:0]  LOOP = 6'h3B;
   localparam logic [31:0] RV   = 32'h0000_0400;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [31:0] instr = '0;
   logic [31:0] rsv = '0;
   logic [31:0] pc, npc, wdat;
   logic        wen;
   logic [4:0]  widx;
   int total = 0;
   int bad = 0;
   logic [31:0] exp_pc;
   bit finished = 0;

   always #10 clk = ~clk;

   loop_step_unit u0 (.clk(clk), .rst(rst), .instr_i(instr), .rs_val_i(rsv),
      .pc_o(pc), .next_pc_o(npc), .wb_en_o(wen), .wb_idx_o(widx), .wb_data_o(wdat));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h instr=%h rs=%h", req, act, exp, instr, rsv);
      end
   endtask

   // drive at current falling edge, check, then move to the next falling edge
   task automatic step(input logic [5:0] op, input logic [4:0] ri,
                       input logic [15:0] im, input logic [31:0] v);
      logic take;
      logic [31:0] nxt;
      instr = {op, ri, 5'd7, im};
      rsv = v;
      #1;
      check("R7", pc, exp_pc);
      take = (op == LOOP) && (ri != 0) && ($signed(v) > 0);
      nxt = take ? exp_pc + 32'd4 + {{14{im[15]}}, im, 2'b00} : exp_pc + 32'd4;
      if (op != LOOP) check("R2", npc, exp_pc + 32'd4);
      else if (ri == 0) check("R6", {31'd0, wen}, 32'd0);
      else if (!take) check("R5", {31'd0, wen}, 32'd0);
      if (take) begin
         check("R3", {31'd0, wen}, 32'd1);
         check("R3", {27'd0, widx}, {27'd0, ri});
         check("R3", wdat, v - 32'd1);
         check("R4", npc, nxt);
      end else begin
         check(op != LOOP ? "R2" : (ri == 0 ? "R6" : "R5"), npc, nxt);
      end
      exp_pc = nxt;
      @(negedge clk);
   endtask

   initial begin
      logic [31:0] vals [7];
      logic [15:0] imms [6];
      vals = '{32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'd0, 32'd1, 32'd2, 32'h7FFF_FFFF, 32'h8000_0000};
      imms = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'hFFF0};
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1", pc, RV);
      rst = 1'b0;
      exp_pc = RV;
      for (int o = 0; o < 64; o++) step(6'(o), 5'd3, 16'hFFF8, 32'd5);
      for (int r = 0; r < 32; r++)
         for (int k = 0; k < 7; k++) step(LOOP, 5'(r), 16'h0010, vals[k]);
      for (int m = 0; m < 6; m++) step(LOOP, 5'd9, imms[m], 32'd3);
      for (int c = 3; c >= 0; c--) step(LOOP, 5'd12, 16'hFFFE, 32'(c));
      // reset mid-run
      rst = 1'b1;
      @(negedge clk);
      check("R1", pc, RV);
      rst = 1'b0;
      exp_pc = RV;
      step(6'h00, 5'd1, 16'h0004, 32'd1);
      step(LOOP, 5'd1, 16'h0004, 32'd1);
      #1 check("R7", pc, exp_pc);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule